// File: doc/BRIEF.md
# Event Tag Number Generator

This block sits in a trigger framework and keeps two 40-bit event scalers. The first one, the start count, advances on every start-digitize command sent to the front ends. The second one, the transfer count, advances only when an event actually moves to the second-level system.

An event is transferred in one of two ways. Either a Level 1 trigger fires that needs no further approval, or a trigger that needs intermediate confirmation receives it. A rejection from the confirmation stage leaves the transfer count where it was.

From the two scalers the block splices a 16-bit tag for the readout crates and the second-level controllers:

- The upper twelve bits of the tag are the low twelve bits of the start count.
- The lower four bits of the tag are the low four bits of the transfer count.

The full transfer count is also presented as a 40-bit trigger number for the event header. The trigger number and the tag therefore agree only in their lowest four bits.

Both scalers advance after their qualifying condition. The values presented at any time therefore label the next trigger.

Transfer control is a two-state machine:

- **ST_IDLE**: no event is waiting. Its transitions are:
  - *direct*: fire with the confirmation flag low; transfer, stay in ST_IDLE.
  - *hold*: fire with the flag high; no transfer, go to ST_AWAIT.
- **ST_AWAIT**: one event is held until the confirmation stage answers. Its transitions are:
  - *confirm*: transfer, return to ST_IDLE.
  - *reject*: no transfer, return to ST_IDLE.
  - *wait*: anything else; stay in ST_AWAIT.

Top module: `evtag_gen`

## Requirements
- R1: After a synchronous reset both scalers are zero, so the tag and the trigger number read zero.
- R2: Every clock cycle with the start-digitize input high adds exactly one to the start count.
- R3: In ST_IDLE, a fire with the confirmation flag low (direct) adds one to the transfer count.
- R4: In ST_IDLE, a fire with the confirmation flag high (hold) leaves the transfer count unchanged and enters ST_AWAIT. A later confirm pulse (confirm) adds one and returns to ST_IDLE.
- R5: In ST_AWAIT, a reject pulse (reject) returns to ST_IDLE without changing the transfer count.
- R6: Tag bits 15..4 equal bits 11..0 of the start count.
- R7: Tag bits 3..0 equal bits 3..0 of the transfer count.
- R8: The 40-bit trigger number equals the whole transfer count.
- R9: Timing of the outputs:
  - A qualifying input in cycle N changes the tag and trigger number after the second rising edge that follows it.
  - After only the first of those edges the outputs still hold their old value.
- R10: In ST_AWAIT, further fire inputs are ignored whatever the confirmation flag; only the held event can be transferred.
- R11: In ST_IDLE, confirm and reject pulses have no effect.
- R12: Each scaler wraps from all ones to zero.
- R13: In ST_AWAIT, confirm and reject together count as a reject.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sdig_i | input | 1 | Start-digitize command, one count per high cycle |
| l1_fire_i | input | 1 | Level 1 trigger fired |
| need_conf_i | input | 1 | The firing trigger requires intermediate confirmation |
| conf_i | input | 1 | Intermediate stage confirms the held event |
| rej_i | input | 1 | Intermediate stage rejects the held event |
| tag_o | output | 16 | Spliced event tag |
| trig_num_o | output | 40 | Full transfer count for the event header |

## Verification
A qualifying input in cycle N is taken into a scaler at the first rising edge. It reaches the output registers at the second rising edge.

The bench therefore drives each stimulus just after a falling edge. It checks that the outputs are still unchanged after the first rising edge, and samples the new values at the falling edge after the second.

The checker relates each scaler to its own value one cycle earlier. It relates each output to the scaler values one cycle earlier, so every property looks exactly one edge back.

// File: rtl/evtag_pkg.sv
package evtag_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_AWAIT = 1'b1
    } evtag_state_t;

endpackage

// File: rtl/evtag_scaler.sv
module evtag_scaler #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/evtag_xfer_fsm.sv
module evtag_xfer_fsm
    import evtag_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         l1_fire,
    input  logic         need_conf,
    input  logic         conf,
    input  logic         rej,
    output logic         xfer,
    output evtag_state_t state
);

    evtag_state_t state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions: direct, hold, confirm, reject, wait
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (l1_fire && need_conf) begin
                    state_nx = ST_AWAIT;
                end
            end
            ST_AWAIT: begin
                if (rej || conf) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs: a reject has priority over a simultaneous confirm
    always_comb begin
        xfer = 1'b0;
        unique case (state)
            ST_IDLE:  xfer = l1_fire && !need_conf;
            ST_AWAIT: xfer = conf && !rej;
            default:  xfer = 1'b0;
        endcase
    end

endmodule

// File: rtl/evtag_tag_fmt.sv
module evtag_tag_fmt #(
    parameter int CNT_W = 40,
    parameter int HI_W  = 12,
    parameter int LO_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CNT_W-1:0]     sd_cnt,
    input  logic [CNT_W-1:0]     xf_cnt,
    output logic [HI_W+LO_W-1:0] tag,
    output logic [CNT_W-1:0]     trig_num
);

    localparam int TAG_W = HI_W + LO_W;

    logic [TAG_W-1:0] tag_nx;

    assign tag_nx = {sd_cnt[HI_W-1:0], xf_cnt[LO_W-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            tag      <= '0;
            trig_num <= '0;
        end else begin
            tag      <= tag_nx;
            trig_num <= xf_cnt;
        end
    end

endmodule

// File: rtl/evtag_gen.sv
module evtag_gen
    import evtag_pkg::*;
#(
    parameter int CNT_W = 40,
    parameter int HI_W  = 12,
    parameter int LO_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sdig_i,
    input  logic                 l1_fire_i,
    input  logic                 need_conf_i,
    input  logic                 conf_i,
    input  logic                 rej_i,
    output logic [HI_W+LO_W-1:0] tag_o,
    output logic [CNT_W-1:0]     trig_num_o
);

    localparam int N_SCL   = 2;
    localparam int IDX_SD  = 0;
    localparam int IDX_XF  = 1;

    evtag_state_t     state;
    logic             xfer;
    logic [N_SCL-1:0] scl_inc;
    logic [CNT_W-1:0] scl_cnt [N_SCL];
    logic [CNT_W-1:0] sd_cnt;
    logic [CNT_W-1:0] xf_cnt;

    evtag_xfer_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .l1_fire   (l1_fire_i),
        .need_conf (need_conf_i),
        .conf      (conf_i),
        .rej       (rej_i),
        .xfer      (xfer),
        .state     (state)
    );

    assign scl_inc[IDX_SD] = sdig_i;
    assign scl_inc[IDX_XF] = xfer;

    for (genvar g = 0; g < N_SCL; g++) begin : g_scl
        evtag_scaler #(.W(CNT_W)) u_scl (
            .clk   (clk),
            .rst   (rst),
            .inc   (scl_inc[g]),
            .count (scl_cnt[g])
        );
    end

    assign sd_cnt = scl_cnt[IDX_SD];
    assign xf_cnt = scl_cnt[IDX_XF];

    evtag_tag_fmt #(.CNT_W(CNT_W), .HI_W(HI_W), .LO_W(LO_W)) u_fmt (
        .clk      (clk),
        .rst      (rst),
        .sd_cnt   (sd_cnt),
        .xf_cnt   (xf_cnt),
        .tag      (tag_o),
        .trig_num (trig_num_o)
    );

endmodule

// File: rtl/evtag_chk.sv
module evtag_chk
    import evtag_pkg::*;
#(
    parameter int CNT_W = 40,
    parameter int HI_W  = 12,
    parameter int LO_W  = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 sdig_i,
    input logic                 l1_fire_i,
    input logic                 need_conf_i,
    input logic                 conf_i,
    input logic                 rej_i,
    input logic [HI_W+LO_W-1:0] tag_o,
    input logic [CNT_W-1:0]     trig_num_o,
    input logic [CNT_W-1:0]     sd_cnt,
    input logic [CNT_W-1:0]     xf_cnt,
    input evtag_state_t         state
);

    localparam int TAG_W = HI_W + LO_W;

    a_r2_sd_step: assert property (@(posedge clk) disable iff (rst)
        sdig_i |=> sd_cnt == CNT_W'($past(sd_cnt) + 1'b1));

    a_r2_sd_hold: assert property (@(posedge clk) disable iff (rst)
        !sdig_i |=> $stable(sd_cnt));

    a_r3_direct: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && l1_fire_i && !need_conf_i) |=> xf_cnt == CNT_W'($past(xf_cnt) + 1'b1));

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && l1_fire_i && need_conf_i) |=> ($stable(xf_cnt) && state == ST_AWAIT));

    a_r4_confirm: assert property (@(posedge clk) disable iff (rst)
        (state == ST_AWAIT && conf_i && !rej_i) |=> (xf_cnt == CNT_W'($past(xf_cnt) + 1'b1) && state == ST_IDLE));

    a_r5_reject: assert property (@(posedge clk) disable iff (rst)
        (state == ST_AWAIT && rej_i) |=> ($stable(xf_cnt) && state == ST_IDLE));

    a_r6_tag_hi: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> tag_o[TAG_W-1:LO_W] == $past(sd_cnt[HI_W-1:0]));

    a_r7_tag_lo: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> tag_o[LO_W-1:0] == $past(xf_cnt[LO_W-1:0]));

    a_r8_trig_num: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> trig_num_o == $past(xf_cnt));

    a_r10_fire_ignored: assert property (@(posedge clk) disable iff (rst)
        (state == ST_AWAIT && !conf_i) |=> $stable(xf_cnt));

    a_r11_idle_pulses: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !l1_fire_i && (conf_i || rej_i)) |=> ($stable(xf_cnt) && state == ST_IDLE));

endmodule

bind evtag_gen evtag_chk #(.CNT_W(CNT_W), .HI_W(HI_W), .LO_W(LO_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sdig_i      (sdig_i),
    .l1_fire_i   (l1_fire_i),
    .need_conf_i (need_conf_i),
    .conf_i      (conf_i),
    .rej_i       (rej_i),
    .tag_o       (tag_o),
    .trig_num_o  (trig_num_o),
    .sd_cnt      (sd_cnt),
    .xf_cnt      (xf_cnt),
    .state       (state)
);

// File: tb/tb_evtag_gen.sv
module tb_evtag_gen;

    localparam int  CLK_P  = 10;
    localparam int  CNT_W  = 40;
    localparam int  W_SML  = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sdig = 1'b0, l1 = 1'b0, need = 1'b0, conf = 1'b0, rej = 1'b0;
    logic w_sd = 1'b0, w_l1 = 1'b0;
    logic [15:0]       tag;
    logic [CNT_W-1:0]  trig;
    logic [15:0]       w_tag;
    logic [W_SML-1:0]  w_trig;

    int n_chk = 0;
    int n_bad = 0;
    logic [CNT_W-1:0] sd_exp = '0;
    logic [CNT_W-1:0] xf_exp = '0;

    always #(CLK_P/2) clk = ~clk;

    evtag_gen dut (
        .clk(clk), .rst(rst), .sdig_i(sdig), .l1_fire_i(l1), .need_conf_i(need),
        .conf_i(conf), .rej_i(rej), .tag_o(tag), .trig_num_o(trig)
    );

    evtag_gen #(.CNT_W(W_SML)) dut_w (
        .clk(clk), .rst(rst), .sdig_i(w_sd), .l1_fire_i(w_l1), .need_conf_i(1'b0),
        .conf_i(1'b0), .rej_i(1'b0), .tag_o(w_tag), .trig_num_o(w_trig)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // compare both outputs of the main instance with the bench model
    task automatic check_outs(input string req);
        check({req, " R6 tag_hi"}, 64'(tag[15:4]), 64'(sd_exp[11:0]));
        check({req, " R7 tag_lo"}, 64'(tag[3:0]), 64'(xf_exp[3:0]));
        check({req, " R8 trig_num"}, 64'(trig), 64'(xf_exp));
    endtask

    // one-cycle stimulus, then one more cycle so the output register catches up
    task automatic stim(input logic s, input logic f, input logic n, input logic c, input logic r);
        @(negedge clk);
        sdig = s; l1 = f; need = n; conf = c; rej = r;
        @(negedge clk);
        sdig = 0; l1 = 0; need = 0; conf = 0; rej = 0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        sd_exp = '0; xf_exp = '0;
        check_outs("R1 reset");
    endtask

    task automatic t_sdig;
        stim(1, 0, 0, 0, 0); sd_exp++;
        check_outs("R2 single start");
        @(negedge clk); sdig = 1;
        repeat (5) @(negedge clk);
        sdig = 0; sd_exp += 5;
        @(negedge clk);
        check_outs("R2 five starts");
    endtask

    task automatic t_timing;
        @(negedge clk); sdig = 1; l1 = 1;
        @(negedge clk); sdig = 0; l1 = 0;
        check_outs("R9 unchanged after first edge");
        sd_exp++; xf_exp++;
        @(negedge clk);
        check_outs("R9 updated after second edge");
    endtask

    task automatic t_direct;
        for (int i = 0; i < 3; i++) begin
            stim(1, 1, 0, 0, 0); sd_exp++; xf_exp++;
        end
        check_outs("R3 direct transfers");
    endtask

    task automatic t_confirm;
        stim(1, 1, 1, 0, 0); sd_exp++;
        check_outs("R4 held, no transfer");
        stim(0, 0, 0, 1, 0); xf_exp++;
        check_outs("R4 confirmed");
    endtask

    task automatic t_reject;
        stim(1, 1, 1, 0, 0); sd_exp++;
        stim(0, 0, 0, 0, 1);
        check_outs("R5 rejected");
        stim(0, 1, 0, 0, 0); xf_exp++;
        check_outs("R5 back in idle, direct counts");
    endtask

    task automatic t_pending_fire;
        stim(1, 1, 1, 0, 0); sd_exp++;
        stim(0, 1, 0, 0, 0);
        stim(0, 1, 1, 0, 0);
        check_outs("R10 fires while held ignored");
        stim(0, 0, 0, 1, 0); xf_exp++;
        check_outs("R10 one transfer only");
    endtask

    task automatic t_idle_pulses;
        stim(0, 0, 0, 1, 0);
        stim(0, 0, 0, 0, 1);
        check_outs("R11 idle confirm/reject ignored");
        stim(0, 1, 1, 0, 0);
        stim(0, 0, 0, 1, 0); xf_exp++;
        check_outs("R11 machine still idle before hold");
    endtask

    task automatic t_both;
        stim(0, 1, 1, 0, 0);
        stim(0, 0, 0, 1, 1);
        check_outs("R13 confirm+reject is reject");
        stim(0, 0, 0, 1, 0);
        check_outs("R13 state left held event");
    endtask

    task automatic t_spread;
        for (int i = 0; i < 20; i++) begin
            stim(1, 1, 0, 0, 0); sd_exp++; xf_exp++;
        end
        check_outs("R7 low nibble rolled past 16");
    endtask

    task automatic t_wrap;
        @(negedge clk); w_sd = 1; w_l1 = 1;
        repeat ((1 << W_SML) - 1) @(negedge clk);
        w_sd = 0; w_l1 = 0;
        @(negedge clk);
        check("R12 start count all ones", 64'(w_tag[15:4]), 64'hFFF);
        check("R12 transfer count all ones", 64'(w_trig), 64'hFFF);
        @(negedge clk); w_sd = 1; w_l1 = 1;
        @(negedge clk); w_sd = 0; w_l1 = 0;
        @(negedge clk);
        check("R12 start count wrapped", 64'(w_tag[15:4]), 64'h0);
        check("R12 transfer count wrapped", 64'(w_trig), 64'h0);
    endtask

    bit done = 0;

    initial begin
        t_reset();
        t_sdig();
        t_timing();
        t_direct();
        t_confirm();
        t_reject();
        t_pending_fire();
        t_idle_pulses();
        t_both();
        t_spread();
        t_wrap();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule